// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational arithmetic logic unit for two's complement words. It is built from a chain of identical one-bit slices. Each slice holds a full adder and a four-way output selector that picks between the bitwise AND, the bitwise OR, the adder sum and a "less" input. The slices are joined by a ripple carry chain.

Subtraction uses the same adder. A single negate control inverts every bit of the second operand and also supplies the carry into the lowest slice. Set-on-less-than takes a comparison bit from the top slice and returns it to bit 0 of the result. That comparison bit is the sign of the difference, corrected for overflow. A wide NOR over the result gives a zero flag, so a subtraction also serves as an equality test.

The block is meant to sit between operand selection and the writeback stage of a simple integer datapath. It has no clock and no state.

Top module: `bitslice_alu`

## Requirements
- R1: With opCode 3'b000, result is the bitwise AND of opA and opB.
- R2: With opCode 3'b001, result is the bitwise OR of opA and opB.
- R3: With opCode 3'b010, result is opA + opB modulo 2^32. carryOut is bit 32 of the unsigned 33-bit sum.
- R4: With opCode 3'b110, result is opA − opB modulo 2^32, formed as opA + ~opB + 1. carryOut is bit 32 of that unsigned sum, which is 1 exactly when opA ≥ opB unsigned.
- R5: With opCode 3'b111, result bit 0 is 1 exactly when opA < opB as signed values, and bits 31..1 are 0. This holds even when opA − opB overflows.
- R6: zero is 1 exactly when all result bits are 0. In particular, a subtraction of equal operands drives zero to 1.
- R7: For addition, overflow is 1 exactly when both operands have the same sign and the result sign differs from it. Addition of operands with different signs never flags overflow.
- R8: For subtraction, overflow is 1 when a non-negative minus a negative gives a negative result, or when a negative minus a non-negative gives a non-negative result. Subtraction of operands with the same sign never flags overflow.
- R9: overflow is 0 for every opCode other than 3'b010 and 3'b110.
- R10: The unused opCodes 3'b011, 3'b100 and 3'b101 drive a result of 0 and zero = 1. For these codes, carryOut is bit 32 of opA + (opB XOR {32{opCode[2]}}) + opCode[2]. For every opCode other than add and subtract, carryOut follows that same formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand, two's complement |
| opB | input | 32 | Second operand, two's complement |
| opCode | input | 3 | Function select; bit 2 is the negate control for opB |
| result | output | 32 | Selected function output |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carryOut | output | 1 | Carry out of the top slice |

## Verification
The assertions sit beside the selector logic and check several properties whenever the inputs change:
- the upper result bits stay clear on set-on-less-than;
- the overflow flag is held at 0 outside add and subtract, and for mixed-sign addition and same-sign subtraction;
- equal operands under subtraction raise the zero flag;
- unused codes give an all-zero result.

The exact result values, the carry chain and the overflow-corrected comparison cannot be expressed as assertions here. They are shown by the bench scenarios. These walk every operation across the extreme operands (0, 1, −1, the largest and the smallest integer) and across random words, and compare the outputs with an independent arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_AND = 3'b000;
  localparam logic [OP_W-1:0] OP_OR  = 3'b001;
  localparam logic [OP_W-1:0] OP_ADD = 3'b010;
  localparam logic [OP_W-1:0] OP_SUB = 3'b110;
  localparam logic [OP_W-1:0] OP_SLT = 3'b111;

  // Slice output selector, encoded as the low two opcode bits.
  typedef enum logic [1:0] {
    PICK_AND  = 2'd0,
    PICK_OR   = 2'd1,
    PICK_SUM  = 2'd2,
    PICK_LESS = 2'd3
  } pick_t;

  // Strobes passed from decode to the datapath.
  typedef struct packed {
    logic  negB;     // invert opB and carry 1 into slice 0
    pick_t pick;     // per-slice output choice
    logic  arith;    // overflow may be reported
    logic  gateOff;  // unused code: force result to zero
  } aluStrobe_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strobe
);
  always_comb begin
    strobe.negB    = opCode[OP_W-1];
    strobe.pick    = pick_t'(opCode[1:0]);
    strobe.arith   = (opCode == OP_ADD) || (opCode == OP_SUB);
    strobe.gateOff = !((opCode == OP_AND) || (opCode == OP_OR) ||
                       (opCode == OP_ADD) || (opCode == OP_SUB) ||
                       (opCode == OP_SLT));
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic  aIn,
  input  logic  bIn,
  input  logic  carryIn,
  input  logic  lessIn,
  input  logic  negB,
  input  pick_t pick,
  output logic  resBit,
  output logic  sumBit,
  output logic  carryOut
);
  logic bEff;

  always_comb begin
    bEff     = bIn ^ negB;
    sumBit   = aIn ^ bEff ^ carryIn;
    carryOut = (aIn & bEff) | (aIn & carryIn) | (bEff & carryIn);
    unique case (pick)
      PICK_AND: resBit = aIn & bEff;
      PICK_OR:  resBit = aIn | bEff;
      PICK_SUM: resBit = sumBit;
      default:  resBit = lessIn;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carryVec;
  logic [WIDTH-1:0] sumVec;
  logic [WIDTH-1:0] rawRes;
  logic [WIDTH-1:0] lessVec;
  logic             ovfRaw;
  logic             setBit;

  assign carryVec[0] = strobe.negB;
  // Only slice 0 sees the comparison; the other slices get 0.
  assign lessVec     = {{(WIDTH-1){1'b0}}, setBit};

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .aIn     (opA[i]),
      .bIn     (opB[i]),
      .carryIn (carryVec[i]),
      .lessIn  (lessVec[i]),
      .negB    (strobe.negB),
      .pick    (strobe.pick),
      .resBit  (rawRes[i]),
      .sumBit  (sumVec[i]),
      .carryOut(carryVec[i+1])
    );
  end

  always_comb begin
    ovfRaw   = carryVec[WIDTH] ^ carryVec[MSB];
    setBit   = sumVec[MSB] ^ ovfRaw;
    result   = strobe.gateOff ? '0 : rawRes;
    zero     = ~|result;
    overflow = strobe.arith & ovfRaw;
    carryOut = carryVec[WIDTH];
  end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [OP_W-1:0]  opCode,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);
  localparam int MSB = WIDTH - 1;

  aluStrobe_t strobe;

  alu_ctrl u_ctrl (
    .opCode(opCode),
    .strobe(strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .result  (result),
    .zero    (zero),
    .overflow(overflow),
    .carryOut(carryOut)
  );

  always_comb begin
    if (opCode == OP_SUB && opA == opB)
      p_eq_zero_r6: assert (zero) else $error("R6 equal subtract not zero");
    if (opCode == OP_SLT)
      p_slt_upper_r5: assert (result[MSB:1] == '0) else $error("R5 upper bits set");
    if (opCode != OP_ADD && opCode != OP_SUB)
      p_no_overflow_r9: assert (!overflow) else $error("R9 overflow on non-arith");
    if (opCode == OP_ADD && opA[MSB] != opB[MSB])
      p_mixed_add_r7: assert (!overflow) else $error("R7 mixed-sign add overflow");
    if (opCode == OP_SUB && opA[MSB] == opB[MSB])
      p_same_sub_r8: assert (!overflow) else $error("R8 same-sign subtract overflow");
    if (opCode == 3'b011 || opCode == 3'b100 || opCode == 3'b101)
      p_unused_r10: assert (result == '0 && zero) else $error("R10 unused code output");
  end
endmodule

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  op;
    logic [31:0] res;
    logic        zf;
    logic        of;
    logic        cf;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opCode = '0;
  logic [31:0] result;
  logic        zero, overflow, carryOut;

  int total = 0;
  int bad = 0;
  bit driveDone = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  bitslice_alu dut (
    .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .zero(zero), .overflow(overflow), .carryOut(carryOut)
  );

  function automatic string resTag(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic item_t model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [2:0] op);
    item_t it;
    logic [32:0] wide;
    logic [31:0] s;
    it.a = a; it.b = b; it.op = op;
    wide = {1'b0, a} + {1'b0, (op[2] ? ~b : b)} + {32'd0, op[2]};
    it.cf = wide[32];
    it.of = 1'b0;
    case (op)
      3'b000: it.res = a & b;
      3'b001: it.res = a | b;
      3'b010: begin
        s = a + b;
        it.res = s;
        it.of = ($signed(a) >= 0 && $signed(b) >= 0 && $signed(s) < 0) ||
                ($signed(a) < 0 && $signed(b) < 0 && $signed(s) >= 0);
      end
      3'b110: begin
        s = a - b;
        it.res = s;
        it.of = ($signed(a) >= 0 && $signed(b) < 0 && $signed(s) < 0) ||
                ($signed(a) < 0 && $signed(b) >= 0 && $signed(s) >= 0);
      end
      3'b111: it.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: it.res = '0;
    endcase
    it.zf = (it.res == 32'd0);
    return it;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp,
                       input item_t it);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s a=%h b=%h op=%b actual=%h expected=%h",
               tag, what, it.a, it.b, it.op, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] op);
    @(posedge clk);
    opA = a; opB = b; opCode = op;
    sb.push_back(model(a, b, op));
  endtask

  // Monitor: compare each expected item half a cycle after it is driven.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        check(result === e.res, resTag(e.op), "result", result, e.res, e);
        check(zero === e.zf, "R6", "zero", {31'd0, zero}, {31'd0, e.zf}, e);
        check(overflow === e.of,
              (e.op == 3'b010) ? "R7" : (e.op == 3'b110) ? "R8" : "R9",
              "overflow", {31'd0, overflow}, {31'd0, e.of}, e);
        check(carryOut === e.cf,
              (e.op == 3'b010) ? "R3" : (e.op == 3'b110) ? "R4" : "R10",
              "carryOut", {31'd0, carryOut}, {31'd0, e.cf}, e);
      end
    end
  end

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h0000_0000;
    corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state: all inputs zero, AND selected.
    drive(32'd0, 32'd0, 3'b000);
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(corner[i], corner[j], op[2:0]);
    // R5: overflowing comparisons, R6: equal operands.
    drive(32'h8000_0000, 32'h0000_0005, 3'b111);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFF0, 3'b111);
    drive(32'h1234_5678, 32'h1234_5678, 3'b110);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = (k % 7 == 0) ? ra : $urandom;
      drive(ra, rb, k[2:0]);
    end
    @(posedge clk);
    wait (sb.size() == 0);
    @(posedge clk);
    driveDone = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!driveDone) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule